// File: doc/BRIEF.md
# Logic Analyzer Sample Strobe Aligner

This block produces the sample-valid strobe and the matching delayed data word for a logic-analyzer capture path. The path shares its clock with an ADC capture path. The strobe comes from one of two sources. The first is a local programmable divider. The second is the valid strobe of the ADC decimation path, used directly because both paths run on the same clock. Slaving to the ADC strobe removes the sample offset of up to one sample that two free-running generators can show. The two generators cannot be aligned through a shared reset, because they count in different ways. Slaving is meaningful only when both paths run at the same effective rate, decimation oversampling included.

The captured digital word and its strobe pass together through a tapped delay line. The tap count is either a value written by software or a fixed function of the decimation-rate code. A change of strobe source is held back until the currently selected source next pulses. This means no strobe is lost or produced twice during a switch.

Top module: `la_strobe_aligner`

## Requirements
- R1: While rst_ni is low, valid_o is 0. The divider counter and the delay line clear. In the first cycle after release, with the reset configuration (internal source, divisor 0, 0 taps), valid_o is 1.
- R2: With the internal source and divisor D written at address 0 (cfg_wdata_i[15:0]), the internal strobe pulses for one clock every D+1 cycles. D = 0 gives a pulse every cycle.
- R3: With the external source active and 0 taps, valid_o equals adc_valid_i in the same cycle, with no added latency.
- R4: The source request is bit 0 of the control register at address 1 (1 = ADC strobe, 0 = internal divider). A new request takes effect only in the cycle after the currently active source pulses. Until then, the old source alone drives the strobe.
- R5: In manual tap mode (control bit 1 = 0), the tap count N is written at address 2 (cfg_wdata_i[2:0]). data_o and valid_o equal the selected strobe and data_i from exactly N cycles earlier.
- R6: In automatic tap mode (control bit 1 = 1), the tap count equals the decimation code in control bits [4:2]. Code 0 gives 0 taps, and the manual tap value is ignored.
- R7: Each valid_o pulse carries in data_o the data_i word that was present when the strobe was selected.
- R8: A write to address 3 changes no setting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock shared with the ADC path |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Register write enable |
| cfg_addr_i | input | 2 | Register address |
| cfg_wdata_i | input | 16 | Register write data |
| data_i | input | 8 | Captured digital inputs |
| adc_valid_i | input | 1 | Valid strobe from the ADC decimation path |
| data_o | output | 8 | Delayed data word |
| valid_o | output | 1 | Delayed sample-valid strobe |

## Verification
The assertions assume that the tap count stays constant while a strobe is in flight, and that adc_valid_i is a single-clock pulse train on the shared clock. The stimulus changes tap settings only after several idle cycles, which lets the delay line drain. It drives adc_valid_i only on falling edges, so every value is stable at the sampling edge. Source switches are timed against a known phase of the internal divider, which keeps the expected cycle of each switch exact.

// File: rtl/la_align_pkg.sv
package la_align_pkg;
  localparam logic [1:0] ADDR_DIV  = 2'd0;
  localparam logic [1:0] ADDR_CTRL = 2'd1;
  localparam logic [1:0] ADDR_TAPS = 2'd2;

  typedef struct packed {
    logic [2:0] dec_code;
    logic       tap_auto;
    logic       src_ext;
  } ctrl_t;

  // decimation code to delay taps
  function automatic logic [2:0] code_to_taps(input logic [2:0] code);
    return code;
  endfunction
endpackage

// File: rtl/la_cfg_regs.sv
module la_cfg_regs
  import la_align_pkg::*;
#(
  parameter int CFG_W = 16,
  parameter int TAP_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [1:0]       addr_i,
  input  logic [CFG_W-1:0] wdata_i,
  output logic [CFG_W-1:0] divisor_o,
  output ctrl_t            ctrl_o,
  output logic [TAP_W-1:0] taps_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      divisor_o <= '0;
      ctrl_o    <= '0;
      taps_o    <= '0;
    end else if (we_i) begin
      unique case (addr_i)
        ADDR_DIV:  divisor_o <= wdata_i;
        ADDR_CTRL: ctrl_o    <= wdata_i[$bits(ctrl_t)-1:0];
        ADDR_TAPS: taps_o    <= wdata_i[TAP_W-1:0];
        default:   ;
      endcase
    end
  end

  // R8
  unmapped_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == 2'd3) |=> ($stable(divisor_o) && $stable(ctrl_o) && $stable(taps_o)));
endmodule

// File: rtl/la_rate_gen.sv
module la_rate_gen #(
  parameter int DIV_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [DIV_W-1:0] divisor_i,
  output logic             pulse_o
);
  logic [DIV_W-1:0] cnt_q;

  assign pulse_o = (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (pulse_o) cnt_q <= divisor_i;
    else              cnt_q <= cnt_q - 1'b1;
  end

  // R2
  count_down_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));
  // R2
  reload_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q == '0) |=> (cnt_q == $past(divisor_i)));
endmodule

// File: rtl/la_strobe_sel.sv
module la_strobe_sel (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic src_req_i,
  input  logic int_valid_i,
  input  logic ext_valid_i,
  output logic valid_o
);
  logic active_q;

  assign valid_o = rst_ni & (active_q ? ext_valid_i : int_valid_i);

  // source swaps only on a pulse of the active source
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      active_q <= 1'b0;
    else if (valid_o) active_q <= src_req_i;
  end

  // R4
  hold_source_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |=> $stable(active_q));
  // R3
  ext_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_q && ext_valid_i && !int_valid_i) |-> valid_o);
endmodule

// File: rtl/la_delay_line.sv
module la_delay_line #(
  parameter int DW       = 8,
  parameter int MAX_TAPS = 7,
  parameter int TAP_W    = $clog2(MAX_TAPS + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [TAP_W-1:0] taps_i,
  input  logic             in_valid_i,
  input  logic [DW-1:0]    in_data_i,
  output logic             out_valid_o,
  output logic [DW-1:0]    out_data_o
);
  localparam int SW = DW + 1;

  logic [SW-1:0] pipe_q [0:MAX_TAPS-1];
  logic [SW-1:0] sel;

  for (genvar i = 0; i < MAX_TAPS; i++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) pipe_q[i] <= '0;
      else if (i == 0) pipe_q[i] <= {in_valid_i, in_data_i};
      else pipe_q[i] <= pipe_q[(i == 0) ? 0 : i - 1];
    end
  end

  always_comb begin
    if (taps_i == '0) sel = {in_valid_i, in_data_i};
    else              sel = pipe_q[taps_i - 1'b1];
  end

  assign out_valid_o = sel[DW];
  assign out_data_o  = sel[DW-1:0];

  // R5
  one_tap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (taps_i == TAP_W'(1) && $past(taps_i) == TAP_W'(1))
      |-> (out_valid_o == $past(in_valid_i) && out_data_o == $past(in_data_i)));
endmodule

// File: rtl/la_strobe_aligner.sv
module la_strobe_aligner
  import la_align_pkg::*;
#(
  parameter int DW       = 8,
  parameter int CFG_W    = 16,
  parameter int MAX_TAPS = 7
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cfg_we_i,
  input  logic [1:0]       cfg_addr_i,
  input  logic [CFG_W-1:0] cfg_wdata_i,
  input  logic [DW-1:0]    data_i,
  input  logic             adc_valid_i,
  output logic [DW-1:0]    data_o,
  output logic             valid_o
);
  localparam int TAP_W = $clog2(MAX_TAPS + 1);

  logic [CFG_W-1:0] divisor;
  ctrl_t            ctrl;
  logic [TAP_W-1:0] man_taps;
  logic [TAP_W-1:0] taps;
  logic             int_valid;
  logic             strobe;

  la_cfg_regs #(.CFG_W(CFG_W), .TAP_W(TAP_W)) u_regs (
    .clk_i, .rst_ni,
    .we_i(cfg_we_i), .addr_i(cfg_addr_i), .wdata_i(cfg_wdata_i),
    .divisor_o(divisor), .ctrl_o(ctrl), .taps_o(man_taps)
  );

  la_rate_gen #(.DIV_W(CFG_W)) u_rate (
    .clk_i, .rst_ni, .divisor_i(divisor), .pulse_o(int_valid)
  );

  la_strobe_sel u_sel (
    .clk_i, .rst_ni,
    .src_req_i(ctrl.src_ext), .int_valid_i(int_valid),
    .ext_valid_i(adc_valid_i), .valid_o(strobe)
  );

  assign taps = ctrl.tap_auto ? TAP_W'(code_to_taps(ctrl.dec_code)) : man_taps;

  la_delay_line #(.DW(DW), .MAX_TAPS(MAX_TAPS), .TAP_W(TAP_W)) u_dly (
    .clk_i, .rst_ni, .taps_i(taps),
    .in_valid_i(strobe), .in_data_i(data_i),
    .out_valid_o(valid_o), .out_data_o(data_o)
  );

  // R1
  always_comb begin
    if (rst_ni === 1'b0) reset_quiet_chk: assert (valid_o == 1'b0);
  end
endmodule

// File: tb/la_strobe_aligner_bench.sv
module la_strobe_aligner_bench;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cfg_we_i = 1'b0;
  logic [1:0]  cfg_addr_i = '0;
  logic [15:0] cfg_wdata_i = '0;
  logic [7:0]  data_i = '0;
  logic        adc_valid_i = 1'b0;
  logic [7:0]  data_o;
  logic        valid_o;
  int n_chk = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  la_strobe_aligner u_la_strobe_aligner (
    .clk_i(clk), .rst_ni, .cfg_we_i, .cfg_addr_i, .cfg_wdata_i,
    .data_i, .adc_valid_i, .data_o, .valid_o
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(negedge clk);
  endtask

  task automatic cfg_write(input logic [1:0] a, input logic [15:0] d);
    cyc();
    cfg_we_i = 1'b1; cfg_addr_i = a; cfg_wdata_i = d;
    cyc();
    cfg_we_i = 1'b0;
    #1;
  endtask

  task automatic idle(input int n);
    adc_valid_i = 1'b0;
    for (int i = 0; i < n; i++) cyc();
    #1;
  endtask

  task automatic t_reset();
    adc_valid_i = 1'b1;
    for (int i = 0; i < 3; i++) begin
      cyc(); #1;
      chk("R1 valid low in reset", valid_o, 1'b0);
    end
    cyc();
    rst_ni = 1'b1; adc_valid_i = 1'b0;
    #1; chk("R1 first cycle after reset", valid_o, 1'b1);
    cyc(); #1; chk("R2 divisor 0 every cycle", valid_o, 1'b1);
  endtask

  // leaves the bench at a cycle where the internal pulse fires (period 4)
  task automatic t_divider();
    int first;
    cfg_write(2'd0, 16'd3);
    first = -1;
    for (int i = 0; i < 6; i++) begin
      if (i > 0) begin cyc(); #1; end
      if (valid_o && first < 0) first = i;
      if (first >= 0) break;
    end
    chk("R2 pulse found", (first >= 0), 1'b1);
    for (int k = 1; k <= 12; k++) begin
      cyc(); #1;
      chk("R2 period D+1", valid_o, (k % 4 == 0));
    end
  endtask

  task automatic t_switch();
    // at pulse cycle c0; write lands at end of c1
    cfg_write(2'd1, 16'h0001);
    adc_valid_i = 1'b1; #1;
    chk("R4 adc ignored before switch (c2)", valid_o, 1'b0);
    cyc(); #1; chk("R4 adc ignored before switch (c3)", valid_o, 1'b0);
    cyc(); #1; chk("R4 internal pulse still used", valid_o, 1'b1);
    for (int i = 0; i < 4; i++) begin
      cyc(); #1; chk("R3 adc strobe passes", valid_o, 1'b1);
    end
    for (int i = 0; i < 6; i++) begin
      cyc(); adc_valid_i = (i == 0 || i == 3 || i == 4); #1;
      chk("R3 same-cycle follow", valid_o, adc_valid_i);
    end
    adc_valid_i = 1'b0;
    cfg_write(2'd1, 16'h0000);
    for (int i = 0; i < 6; i++) begin
      cyc(); #1; chk("R4 internal held off until adc pulse", valid_o, 1'b0);
    end
    cyc(); adc_valid_i = 1'b1; #1;
    chk("R4 last adc pulse passes", valid_o, 1'b1);
    cyc(); adc_valid_i = 1'b1; #1;
    begin
      int seen;
      seen = 0;
      for (int i = 0; i < 5; i++) begin
        if (i > 0) begin cyc(); #1; end
        if (valid_o) begin seen = 1; break; end
      end
      chk("R4 internal source resumes", seen, 1);
      cyc(); #1;
      chk("R4 adc ignored after switch back", valid_o, 1'b0);
    end
    adc_valid_i = 1'b0;
  endtask

  task automatic t_manual_taps();
    logic [7:0] h [0:15];
    cfg_write(2'd0, 16'd0);
    cfg_write(2'd2, 16'd3);
    idle(8);
    for (int k = 0; k < 14; k++) begin
      cyc(); data_i = 8'hA0 + 8'(k); h[k] = data_i; #1;
      if (k >= 3) begin
        chk("R5 data delayed 3", data_o, h[k-3]);
        chk("R5 valid delayed 3", valid_o, 1'b1);
      end
    end
  endtask

  task automatic t_pairing();
    logic [7:0] dh [0:15];
    logic       vh [0:15];
    cfg_write(2'd1, 16'h0001);
    cfg_write(2'd2, 16'd2);
    idle(8);
    for (int k = 0; k < 16; k++) begin
      cyc();
      adc_valid_i = (k == 1 || k == 4 || k == 5 || k == 10);
      data_i = 8'h30 + 8'(k);
      vh[k] = adc_valid_i; dh[k] = data_i; #1;
      chk("R7 valid after 2 taps", valid_o, (k >= 2) ? vh[k-2] : 1'b0);
      if (k >= 2 && vh[k-2]) chk("R7 data paired", data_o, dh[k-2]);
    end
    adc_valid_i = 1'b0;
  endtask

  task automatic t_auto();
    cfg_write(2'd1, 16'h0017); // ext, auto, code 5
    idle(8);
    for (int k = 0; k < 10; k++) begin
      cyc();
      adc_valid_i = (k == 0);
      data_i = (k == 0) ? 8'h55 : 8'h00; #1;
      chk("R6 code 5 gives 5 taps", valid_o, (k == 5));
      if (k == 5) chk("R6 data after 5 taps", data_o, 8'h55);
    end
    cfg_write(2'd1, 16'h0003); // ext, auto, code 0
    idle(8);
    cyc(); adc_valid_i = 1'b1; data_i = 8'h6C; #1;
    chk("R6 code 0 no delay valid", valid_o, 1'b1);
    chk("R6 code 0 no delay data", data_o, 8'h6C);
    cyc(); adc_valid_i = 1'b0; #1;
    chk("R6 single pulse", valid_o, 1'b0);
  endtask

  task automatic t_unmapped();
    cfg_write(2'd3, 16'hFFFF);
    idle(8);
    cyc(); adc_valid_i = 1'b1; data_i = 8'h99; #1;
    chk("R8 taps unchanged", valid_o, 1'b1);
    chk("R8 data unchanged", data_o, 8'h99);
    cyc(); adc_valid_i = 1'b0; #1;
    chk("R8 source unchanged", valid_o, 1'b0);
  endtask

  initial begin
    t_reset();
    t_divider();
    t_switch();
    t_manual_taps();
    t_pairing();
    t_auto();
    t_unmapped();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #2_000_000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule